// File: doc/BRIEF.md
# Split Serial Access Buffer

This block is a 256-word by 8-bit serial buffer that sits next to a row-organised RAM. A transfer request moves a whole row between the RAM and the buffer in either direction. The transfer also sets the place in the buffer where serial streaming starts. A serial port then reads the buffer one word per enabled clock, and it can also write one word per enabled clock. The serial pointer advances through the buffer on its own, with no further help from the RAM side.

The buffer can also run as two halves of 128 words each. A split transfer reloads only the half that the serial port is not using. It also records where streaming is to resume in that half. When the pointer runs off the end of the active half, it jumps straight to that recorded start in the other half. Output therefore carries on with no idle cycle while the RAM side refills the half just left. A flag output shows which half is active.

Top module: `split_serial_buffer`

## Requirements
- R1: After reset the serial pointer is 0, the half flag is 0, split mode is off, `ram_wr_half` is 00, and the next clock with serial enable set moves the pointer to 1.
- R2: A full load (`xfer_valid`=1, `xfer_split`=0, `xfer_to_ram`=0) copies every word of `row_in` into the buffer. Word i is `row_in[8i+7:8i]`. The pointer becomes `xfer_start` on the next clock.
- R3: A full store (`xfer_valid`=1, `xfer_split`=0, `xfer_to_ram`=1) drives `ram_wr_half`=11 in that same cycle. `row_out` always shows word i of the buffer at bits `[8i+7:8i]`.
- R4: With no transfer and no split mode, each clock with `ser_en`=1 adds one to the pointer, wrapping from 255 to 0. With `ser_en`=0 and no transfer the pointer holds. `ser_dout` always shows the word at the pointer.
- R5: When `ser_en`=1 and `ser_wr`=1, `ser_din` is written to the word at the current pointer before the pointer moves.
- R6: A split load changes only the half selected by `xfer_start[7]` (0 = lower words 0..127, 1 = upper words 128..255). The other half and the pointer are left as they were.
- R7: In split mode, an enabled clock with the pointer at the last word of a half moves the pointer into the other half. It lands at the start offset most recently recorded for that half, and the half flag toggles.
- R8: `half_flag` is 0 while the pointer is in the lower half and 1 while it is in the upper half.
- R9: A split transfer whose `xfer_start[7]` equals `half_flag` is ignored. The buffer is unchanged, `ram_wr_half` stays 00, and the recorded start offset and mode are unchanged.
- R10: A split store drives `ram_wr_half` one-hot in that cycle for the target half: bit 0 for the lower half, bit 1 for the upper half.
- R11: A split transfer that is accepted turns split mode on. A full transfer turns it off, so the pointer then passes from 127 to 128 with no jump.
- R12: A full transfer in the same cycle as a serial access takes priority, and the serial write is dropped. A split transfer in the same cycle as serial streaming lets the pointer advance as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock |
| rst_n | input | 1 | Active-low reset |
| xfer_valid | input | 1 | Transfer request for this cycle |
| xfer_split | input | 1 | 1 = split (half) transfer, 0 = full transfer |
| xfer_to_ram | input | 1 | 1 = buffer to RAM, 0 = RAM to buffer |
| xfer_start | input | 8 | Serial start address; bit 7 selects the half in split transfers |
| row_in | input | 2048 | Row data from RAM, word i at bits 8i+7:8i |
| row_out | output | 2048 | Buffer contents toward RAM, word i at bits 8i+7:8i |
| ram_wr_half | output | 2 | Halves to be written into RAM this cycle (bit 0 lower, bit 1 upper) |
| ser_en | input | 1 | Serial enable: access and advance this clock |
| ser_wr | input | 1 | Serial write when enabled |
| ser_din | input | 8 | Serial write data |
| ser_dout | output | 8 | Word at the serial pointer |
| ser_ptr | output | 8 | Current serial pointer |
| half_flag | output | 1 | Active half: 0 lower, 1 upper |

## Verification
The bench streams across the 255-to-0 wrap in full mode. A design that jumped there, or stalled there, would show the wrong pointer. It drives the pointer across both half boundaries in split mode. A design that only incremented would land at 128 or 0, not at the recorded offset. One split load is issued in the same cycle as the boundary stream, and one targets the active half. The second would overwrite words being read if it were not ignored. A final full load arrives together with a serial write and shows that split mode has been cleared. The write must be dropped, and the later 127-to-128 step must not jump.

// File: rtl/sab_pkg.sv
package sab_pkg;
  typedef enum logic [1:0] {
    XF_NONE    = 2'd0,
    XF_FULL    = 2'd1,
    XF_SPLIT   = 2'd2,
    XF_IGNORED = 2'd3
  } xfer_kind_t;
endpackage

// File: rtl/sab_xfer_decode.sv
module sab_xfer_decode (
  input  logic       xfer_valid,
  input  logic       xfer_split,
  input  logic       xfer_to_ram,
  input  logic       tgt_half,
  input  logic       act_half,
  output logic       full_ld,
  output logic       full_st,
  output logic       split_ld,
  output logic       split_st,
  output logic [1:0] ram_wr_half
);
  import sab_pkg::*;

  xfer_kind_t kind;

  always_comb begin
    if (!xfer_valid)               kind = XF_NONE;
    else if (!xfer_split)          kind = XF_FULL;
    else if (tgt_half != act_half) kind = XF_SPLIT;
    else                           kind = XF_IGNORED;
  end

  assign full_ld  = (kind == XF_FULL)  && !xfer_to_ram;
  assign full_st  = (kind == XF_FULL)  &&  xfer_to_ram;
  assign split_ld = (kind == XF_SPLIT) && !xfer_to_ram;
  assign split_st = (kind == XF_SPLIT) &&  xfer_to_ram;

  always_comb begin
    ram_wr_half = 2'b00;
    if (full_st)       ram_wr_half = 2'b11;
    else if (split_st) ram_wr_half = tgt_half ? 2'b10 : 2'b01;
  end
endmodule

// File: rtl/sab_pointer.sv
module sab_pointer #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          full_xfer,
  input  logic          split_take,
  input  logic          tgt_half,
  input  logic [AW-1:0] start,
  input  logic          ser_en,
  output logic [AW-1:0] ptr,
  output logic          split_mode,
  output logic          half_jump
);
  localparam int OW = AW - 1;

  logic [OW-1:0] resume_off [2];
  logic          other_half;
  logic [OW-1:0] jump_off;

  function automatic logic [AW-1:0] f_incr(input logic [AW-1:0] p);
    return p + AW'(1);
  endfunction

  function automatic logic f_end_of_half(input logic [AW-1:0] p);
    return &p[OW-1:0];
  endfunction

  assign other_half = ~ptr[AW-1];
  assign half_jump  = ser_en && !full_xfer && split_mode && f_end_of_half(ptr);
  // A split transfer always targets the other half, so its offset bypasses the register.
  assign jump_off   = split_take ? start[OW-1:0] : resume_off[other_half];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr           <= '0;
      split_mode    <= 1'b0;
      resume_off[0] <= '0;
      resume_off[1] <= '0;
    end else if (full_xfer) begin
      ptr        <= start;
      split_mode <= 1'b0;
    end else begin
      if (split_take) begin
        split_mode           <= 1'b1;
        resume_off[tgt_half] <= start[OW-1:0];
      end
      if (half_jump)   ptr <= {other_half, jump_off};
      else if (ser_en) ptr <= f_incr(ptr);
    end
  end
endmodule

// File: rtl/sab_store.sv
module sab_store #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        full_ld,
  input  logic                        split_ld,
  input  logic                        tgt_half,
  input  logic [(1<<AW)*DW-1:0]       row_in,
  input  logic                        ser_we,
  input  logic [AW-1:0]               ptr,
  input  logic [DW-1:0]               din,
  output logic [(1<<AW)*DW-1:0]       row_out,
  output logic [DW-1:0]               dout
);
  localparam int DEPTH = 1 << AW;
  localparam int HALF  = DEPTH / 2;

  logic [DW-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    localparam logic IHI = (i >= HALF);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             mem[i] <= '0;
      else if (full_ld)                       mem[i] <= row_in[i*DW +: DW];
      else if (split_ld && (tgt_half == IHI)) mem[i] <= row_in[i*DW +: DW];
      else if (ser_we && (ptr == AW'(i)))     mem[i] <= din;
    end
    assign row_out[i*DW +: DW] = mem[i];
  end

  assign dout = mem[ptr];
endmodule

// File: rtl/split_serial_buffer.sv
module split_serial_buffer #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  xfer_valid,
  input  logic                  xfer_split,
  input  logic                  xfer_to_ram,
  input  logic [AW-1:0]         xfer_start,
  input  logic [(1<<AW)*DW-1:0] row_in,
  output logic [(1<<AW)*DW-1:0] row_out,
  output logic [1:0]            ram_wr_half,
  input  logic                  ser_en,
  input  logic                  ser_wr,
  input  logic [DW-1:0]         ser_din,
  output logic [DW-1:0]         ser_dout,
  output logic [AW-1:0]         ser_ptr,
  output logic                  half_flag
);
  logic full_ld, full_st, split_ld, split_st;
  logic full_xfer, split_take, tgt_half, ser_we;
  logic split_mode, half_jump;

  assign tgt_half   = xfer_start[AW-1];
  assign half_flag  = ser_ptr[AW-1];
  assign full_xfer  = full_ld | full_st;
  assign split_take = split_ld | split_st;
  assign ser_we     = ser_en & ser_wr & ~full_xfer;

  sab_xfer_decode u_dec (
    .xfer_valid (xfer_valid),
    .xfer_split (xfer_split),
    .xfer_to_ram(xfer_to_ram),
    .tgt_half   (tgt_half),
    .act_half   (half_flag),
    .full_ld    (full_ld),
    .full_st    (full_st),
    .split_ld   (split_ld),
    .split_st   (split_st),
    .ram_wr_half(ram_wr_half)
  );

  sab_pointer #(.AW(AW)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .full_xfer (full_xfer),
    .split_take(split_take),
    .tgt_half  (tgt_half),
    .start     (xfer_start),
    .ser_en    (ser_en),
    .ptr       (ser_ptr),
    .split_mode(split_mode),
    .half_jump (half_jump)
  );

  sab_store #(.AW(AW), .DW(DW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .full_ld (full_ld),
    .split_ld(split_ld),
    .tgt_half(tgt_half),
    .row_in  (row_in),
    .ser_we  (ser_we),
    .ptr     (ser_ptr),
    .din     (ser_din),
    .row_out (row_out),
    .dout    (ser_dout)
  );
endmodule

// File: rtl/sab_checker.sv
module sab_checker #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          xfer_valid,
  input logic          xfer_split,
  input logic          xfer_to_ram,
  input logic [AW-1:0] xfer_start,
  input logic          ser_en,
  input logic [AW-1:0] ser_ptr,
  input logic          half_flag,
  input logic [1:0]    ram_wr_half,
  input logic          split_mode,
  input logic          half_jump,
  input logic          full_xfer
);
  p_full_ptr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    full_xfer |=> ser_ptr == $past(xfer_start));

  p_store_all_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_split && xfer_to_ram) |-> ram_wr_half == 2'b11);

  p_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_en && !xfer_valid && !split_mode) |=> ser_ptr == AW'($past(ser_ptr) + AW'(1)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_en && !xfer_valid) |=> $stable(ser_ptr));

  p_jump_r7: assert property (@(posedge clk) disable iff (!rst_n)
    half_jump |=> half_flag != $past(half_flag));

  p_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_split && (xfer_start[AW-1] == half_flag)) |-> ram_wr_half == 2'b00);

  p_split_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && xfer_split && xfer_to_ram && (xfer_start[AW-1] != half_flag))
      |-> $countones(ram_wr_half) == 1);

  p_mode_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
    full_xfer |=> !split_mode);
endmodule

bind split_serial_buffer sab_checker #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .xfer_valid (xfer_valid),
  .xfer_split (xfer_split),
  .xfer_to_ram(xfer_to_ram),
  .xfer_start (xfer_start),
  .ser_en     (ser_en),
  .ser_ptr    (ser_ptr),
  .half_flag  (half_flag),
  .ram_wr_half(ram_wr_half),
  .split_mode (split_mode),
  .half_jump  (half_jump),
  .full_xfer  (full_xfer)
);

// File: tb/split_serial_buffer_bench.sv
`timescale 1ns/1ps
module split_serial_buffer_bench;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          xfer_valid = 1'b0, xfer_split = 1'b0, xfer_to_ram = 1'b0;
  logic [7:0]    xfer_start = '0;
  logic [2047:0] row_in = '0;
  logic [2047:0] row_out;
  logic [1:0]    ram_wr_half;
  logic          ser_en = 1'b0, ser_wr = 1'b0;
  logic [7:0]    ser_din = '0;
  logic [7:0]    ser_dout, ser_ptr;
  logic          half_flag;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  split_serial_buffer u_split_serial_buffer (
    .clk(clk), .rst_n(rst_n), .xfer_valid(xfer_valid), .xfer_split(xfer_split),
    .xfer_to_ram(xfer_to_ram), .xfer_start(xfer_start), .row_in(row_in),
    .row_out(row_out), .ram_wr_half(ram_wr_half), .ser_en(ser_en), .ser_wr(ser_wr),
    .ser_din(ser_din), .ser_dout(ser_dout), .ser_ptr(ser_ptr), .half_flag(half_flag)
  );

  function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
    return 8'((seed * 5) + (i * 7)) ^ 8'(i >> 3);
  endfunction

  function automatic logic [2047:0] row_of(input logic [7:0] seed);
    logic [2047:0] r;
    for (int i = 0; i < 256; i++) r[i*8 +: 8] = pat(seed, i);
    return r;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    xfer_valid = 0; xfer_split = 0; xfer_to_ram = 0; ser_en = 0; ser_wr = 0;
  endtask

  task automatic stream(input int n);
    ser_en = 1;
    for (int k = 0; k < n; k++) tick();
    ser_en = 0;
  endtask

  task automatic t_reset();
    chk("R1", "ptr", ser_ptr, 0);
    chk("R1", "flag", half_flag, 0);
    chk("R1", "ram_wr_half", ram_wr_half, 0);
    stream(1);
    chk("R1", "first step", ser_ptr, 1);
  endtask

  task automatic t_full_load();
    row_in = row_of(8'h11);
    xfer_valid = 1; xfer_start = 8'd250;
    tick(); idle();
    chk("R2", "ptr after load", ser_ptr, 250);
    chk("R2", "dout at start", ser_dout, pat(8'h11, 250));
  endtask

  task automatic t_stream_wrap();
    for (int p = 251; p <= 256; p++) begin
      stream(1);
      chk("R4", "ptr step", ser_ptr, p % 256);
      chk("R4", "dout step", ser_dout, pat(8'h11, p % 256));
      if (p == 255) chk("R8", "flag upper", half_flag, 1);
    end
    chk("R8", "flag lower", half_flag, 0);
    tick();
    chk("R4", "hold without enable", ser_ptr, 0);
  endtask

  task automatic t_serial_write_and_store();
    ser_en = 1; ser_wr = 1; ser_din = 8'hA5;
    tick(); idle();
    chk("R5", "ptr after write", ser_ptr, 1);
    xfer_valid = 1; xfer_to_ram = 1; xfer_start = 8'd0;
    #1;
    chk("R3", "full store halves", ram_wr_half, 3);
    chk("R5", "written word", row_out[7:0], 8'hA5);
    chk("R3", "row_out word 1", row_out[15:8], pat(8'h11, 1));
    tick(); idle();
    chk("R3", "ptr after store", ser_ptr, 0);
    chk("R5", "dout written", ser_dout, 8'hA5);
  endtask

  task automatic t_split_stream();
    row_in = row_of(8'h22);
    xfer_valid = 1; xfer_split = 1; xfer_start = 8'h90;
    tick(); idle();
    chk("R6", "ptr untouched", ser_ptr, 0);
    chk("R6", "lower half untouched", ser_dout, 8'hA5);
    chk("R6", "upper word loaded", row_out[8'h90*8 +: 8], pat(8'h22, 8'h90));
    chk("R6", "lower word 1 kept", row_out[15:8], pat(8'h11, 1));
    stream(127);
    chk("R7", "ptr at end of lower", ser_ptr, 127);
    stream(1);
    chk("R7", "jump to upper start", ser_ptr, 8'h90);
    chk("R7", "flag toggled", half_flag, 1);
    chk("R7", "dout after jump", ser_dout, pat(8'h22, 8'h90));
    row_in = row_of(8'h33);
    xfer_valid = 1; xfer_split = 1; xfer_start = 8'h05; ser_en = 1;
    tick(); idle();
    chk("R12", "stream during split load", ser_ptr, 8'h91);
    stream(8'hFF - 8'h91);
    chk("R7", "ptr at end of upper", ser_ptr, 8'hFF);
    stream(1);
    chk("R7", "jump to lower start", ser_ptr, 8'h05);
    chk("R7", "flag back", half_flag, 0);
    chk("R6", "dout new lower", ser_dout, pat(8'h33, 5));
  endtask

  task automatic t_split_ignore_and_store();
    row_in = row_of(8'h44);
    xfer_valid = 1; xfer_split = 1; xfer_start = 8'h40;
    tick(); idle();
    chk("R9", "ptr unchanged", ser_ptr, 5);
    chk("R9", "dout unchanged", ser_dout, pat(8'h33, 5));
    stream(1);
    chk("R9", "neighbour unchanged", ser_dout, pat(8'h33, 6));
    xfer_valid = 1; xfer_split = 1; xfer_to_ram = 1; xfer_start = 8'h00;
    #1;
    chk("R9", "ignored store halves", ram_wr_half, 0);
    xfer_start = 8'h80;
    #1;
    chk("R10", "split store upper", ram_wr_half, 2);
    chk("R10", "row_out upper word", row_out[8'h90*8 +: 8], pat(8'h22, 8'h90));
    tick(); idle();
  endtask

  task automatic t_full_clears();
    row_in = row_of(8'h55);
    xfer_valid = 1; xfer_start = 8'h7E;
    ser_en = 1; ser_wr = 1; ser_din = 8'hEE;
    tick(); idle();
    chk("R12", "full wins ptr", ser_ptr, 8'h7E);
    chk("R12", "serial write dropped", ser_dout, pat(8'h55, 8'h7E));
    stream(2);
    chk("R11", "no jump after full", ser_ptr, 8'h80);
    chk("R11", "flag upper", half_flag, 1);
    chk("R11", "dout linear", ser_dout, pat(8'h55, 8'h80));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_full_load();
    t_stream_wrap();
    t_serial_write_and_store();
    t_split_stream();
    t_split_ignore_and_store();
    t_full_clears();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule